// File: doc/BRIEF.md
# Accelerator control register block

This block holds the per-accelerator control state that software programs before and while an accelerator runs. Through a 32-bit register port, software sets an enable flag, assigns a range of process address space identifiers (a base and a log2 count) and a range of context tags (a base and a count). It can also read two fixed capability values: the largest PASID log and the number of context tags the accelerator supports.

The block also carries a PASID-termination handshake. Software writes a PASID together with a busy flag. The block passes the request to the accelerator as a one-cycle pulse, keeps the busy flag set until the accelerator reports completion, and refuses further termination writes in the meantime. The accelerator's own teardown of the process context is outside this block and appears only as the `term_done` input.

Register reads are combinational on `reg_addr`. Writes take effect at the rising clock edge on which `reg_we` is high.

Top module: `accel_ctl_regs`

## Requirements
- R1: After reset, every writable field is 0, the busy flag is 0, and `term_req` is 0. The only non-zero read values are the capability fields.
- R2: Word 0 stores bits 7:0 of a write and reads them back. Bit 0 drives `acc_enable`. Bits 31:8 read as 0.
- R3: Word 1 holds the 20-bit PASID base in bits 19:0, which drive `pasid_base`. Bits 31:20 read as 0 and no write changes them.
- R4: Word 2 holds the writable 5-bit PASID log count in bits 4:0, which drive `pasid_log`. Bits 12:8 read the supported-PASID log capability, and writes to those bits are ignored.
- R5: Word 3 holds the 12-bit context-tag count in bits 11:0 (`tag_count`) and the 12-bit context-tag base in bits 27:16 (`tag_base`).
- R6: Word 4 bits 11:0 read the supported context-tag count. Writes to word 4 are ignored.
- R7: Word 5 holds the termination PASID in bits 19:0 and the busy flag in bit 20. When bit 20 is clear, a write to word 5 with bit 20 set is accepted: both fields load, and `term_req` is high for exactly the one cycle after the write edge, with `term_pasid` equal to the written PASID.
- R8: Bit 20 stays 1 until a cycle in which `term_done` is high, and reads 0 from the next cycle on. A `term_done` pulse while bit 20 is 0 has no effect.
- R9: While bit 20 is set, a write to word 5 is rejected. The PASID field does not change and no `term_req` pulse is produced.
- R10: Clearing the enable bit while a termination is pending does not clear bit 20.
- R11: Words 6 and 7 read as 0, and writes to them change no other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| acc_enable | output | 1 | Accelerator enable level |
| pasid_base | output | 20 | First assigned PASID |
| pasid_log | output | 5 | Log2 of the number of assigned PASIDs |
| tag_base | output | 12 | First assigned context tag |
| tag_count | output | 12 | Number of assigned context tags |
| term_req | output | 1 | One-cycle termination request pulse |
| term_pasid | output | 20 | PASID to terminate |
| term_done | input | 1 | Accelerator reports termination complete |

## Verification
Register fields and their range outputs change at the write edge. Because `reg_rdata` is combinational, a read placed in the cycle after the write edge already shows the new value. `term_req` is high only in the cycle that directly follows the accepting edge, and bit 20 falls one edge after the `term_done` cycle. The bench drives every input at the falling edge and samples at that same falling edge or shortly after it, so each sample lands in the exact cycle in which the result is due. The pulse is checked both in its due cycle and in the cycle after, where it must be low again.

// File: rtl/accel_ctl_regs.sv
module accel_ctl_regs #(
  parameter int PASID_W = 20,
  parameter int TAG_W   = 12,
  parameter int LOG_W   = 5,
  parameter int ADDR_W  = 3,
  parameter logic [LOG_W-1:0] CAP_PASID_LOG = 5'd9,
  parameter logic [TAG_W-1:0] CAP_TAG_COUNT = 12'd160
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               acc_enable,
  output logic [PASID_W-1:0] pasid_base,
  output logic [LOG_W-1:0]   pasid_log,
  output logic [TAG_W-1:0]   tag_base,
  output logic [TAG_W-1:0]   tag_count,
  output logic               term_req,
  output logic [PASID_W-1:0] term_pasid,
  input  logic               term_done
);
  localparam int BUSY_BIT = PASID_W;
  localparam int TAG_LSB  = 16;
  localparam int CAP_LSB  = 8;
  localparam logic [ADDR_W-1:0] A_CTRL = 0, A_PASID = 1, A_PLOG = 2,
                                A_TAG  = 3, A_TCAP  = 4, A_TERM = 5;

  logic [7:0] ctrl_q;
  logic       busy_q;
  logic       unused_wdata;

  assign acc_enable   = ctrl_q[0];
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      pasid_base <= '0;
      pasid_log  <= '0;
      tag_base   <= '0;
      tag_count  <= '0;
      term_pasid <= '0;
      busy_q     <= 1'b0;
      term_req   <= 1'b0;
    end else begin
      term_req <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          A_CTRL:  ctrl_q     <= reg_wdata[7:0];
          A_PASID: pasid_base <= reg_wdata[PASID_W-1:0];
          A_PLOG:  pasid_log  <= reg_wdata[LOG_W-1:0];
          A_TAG: begin
            tag_count <= reg_wdata[TAG_W-1:0];
            tag_base  <= reg_wdata[TAG_LSB +: TAG_W];
          end
          A_TERM: if (!busy_q) begin
            term_pasid <= reg_wdata[PASID_W-1:0];
            busy_q     <= reg_wdata[BUSY_BIT];
            term_req   <= reg_wdata[BUSY_BIT];
          end
          default: ;
        endcase
      end
      if (busy_q && term_done) busy_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[7:0] = ctrl_q;
      A_PASID: reg_rdata[PASID_W-1:0] = pasid_base;
      A_PLOG: begin
        reg_rdata[LOG_W-1:0]         = pasid_log;
        reg_rdata[CAP_LSB +: LOG_W]  = CAP_PASID_LOG;
      end
      A_TAG: begin
        reg_rdata[TAG_W-1:0]         = tag_count;
        reg_rdata[TAG_LSB +: TAG_W]  = tag_base;
      end
      A_TCAP:  reg_rdata[TAG_W-1:0] = CAP_TAG_COUNT;
      A_TERM: begin
        reg_rdata[PASID_W-1:0] = term_pasid;
        reg_rdata[BUSY_BIT]    = busy_q;
      end
      default: ;
    endcase
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    term_req |=> !term_req);
  a_r7_pulse_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    term_req |-> busy_q);
  a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !term_done |=> busy_q);
  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && term_done |=> !busy_q);
  a_r9_reject: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && reg_we && reg_addr == A_TERM |=> !term_req && $stable(term_pasid));
  a_r10_disable_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !term_done && reg_we && reg_addr == A_CTRL |=> busy_q);
endmodule

// File: tb/accel_ctl_regs_bench.sv
`timescale 1ns/1ps
module accel_ctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_enable;
  logic [19:0] pasid_base;
  logic [4:0]  pasid_log;
  logic [11:0] tag_base;
  logic [11:0] tag_count;
  logic        term_req;
  logic [19:0] term_pasid;
  logic        term_done = 1'b0;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  accel_ctl_regs u_accel_ctl_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_enable(acc_enable),
    .pasid_base(pasid_base), .pasid_log(pasid_log), .tag_base(tag_base),
    .tag_count(tag_count), .term_req(term_req), .term_pasid(term_pasid),
    .term_done(term_done)
  );

  // {requirement, address, write data, expected readback}
  localparam logic [71:0] VEC [0:10] = '{
    {4'd2,  4'd0, 32'hFFFF_FF5B, 32'h0000_005B},   // R2
    {4'd2,  4'd0, 32'h0000_0001, 32'h0000_0001},   // R2
    {4'd3,  4'd1, 32'hFFFF_FFFF, 32'h000F_FFFF},   // R3
    {4'd3,  4'd1, 32'h1234_5678, 32'h0004_5678},   // R3
    {4'd4,  4'd2, 32'hFFFF_FFFF, 32'h0000_091F},   // R4
    {4'd4,  4'd2, 32'h0000_0003, 32'h0000_0903},   // R4
    {4'd5,  4'd3, 32'hFFFF_FFFF, 32'h0FFF_0FFF},   // R5
    {4'd5,  4'd3, 32'h0ABC_0123, 32'h0ABC_0123},   // R5
    {4'd6,  4'd4, 32'hFFFF_FFFF, 32'h0000_00A0},   // R6
    {4'd11, 4'd7, 32'hFFFF_FFFF, 32'h0000_0000},   // R11
    {4'd11, 4'd6, 32'hFFFF_FFFF, 32'h0000_0000}    // R11
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 100000);
    total++; bad++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, v); chk("R1 word0", v, 32'h0);
    rd(3'd1, v); chk("R1 word1", v, 32'h0);
    rd(3'd2, v); chk("R1 word2", v, 32'h0000_0900);
    rd(3'd3, v); chk("R1 word3", v, 32'h0);
    rd(3'd4, v); chk("R1 word4", v, 32'h0000_00A0);
    rd(3'd5, v); chk("R1 word5", v, 32'h0);
    chk("R1 outputs", {acc_enable, term_req, pasid_base, pasid_log, tag_base, tag_count}, 32'h0);

    for (int i = 0; i < 11; i++) begin
      wr(VEC[i][66:64], VEC[i][63:32]);
      rd(VEC[i][66:64], v);
      total++;
      if (v !== VEC[i][31:0]) begin
        bad++;
        $display("FAIL R%0d vector %0d: got %h expected %h", VEC[i][71:68], i, v, VEC[i][31:0]);
      end
    end
    // range outputs after the table
    chk("R2 acc_enable", {31'd0, acc_enable}, 32'd1);
    chk("R3 pasid_base", {12'd0, pasid_base}, 32'h0004_5678);
    chk("R4 pasid_log", {27'd0, pasid_log}, 32'd3);
    chk("R5 tag_base/count", {4'd0, tag_base, 4'd0, tag_count}, 32'h0ABC_0123);
    rd(3'd3, v); chk("R11 word3 untouched", v, 32'h0ABC_0123);

    // R7 accepted termination
    wr(3'd5, 32'h0010_0ABC);
    chk("R7 req pulse", {31'd0, term_req}, 32'd1);
    chk("R7 req pasid", {12'd0, term_pasid}, 32'h0000_0ABC);
    rd(3'd5, v); chk("R7 readback busy", v, 32'h0010_0ABC);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'd0, term_req}, 32'd0);

    // R9 rejected while busy
    wr(3'd5, 32'h0010_0555);
    chk("R9 no pulse", {31'd0, term_req}, 32'd0);
    rd(3'd5, v); chk("R9 pasid kept", v, 32'h0010_0ABC);

    // R10 disable does not cancel
    wr(3'd0, 32'h0000_0000);
    chk("R10 enable low", {31'd0, acc_enable}, 32'd0);
    repeat (3) @(negedge clk);
    rd(3'd5, v); chk("R10 R8 still busy", v, 32'h0010_0ABC);

    // R8 done clears
    @(negedge clk); term_done = 1'b1;
    @(negedge clk); term_done = 1'b0;
    rd(3'd5, v); chk("R8 cleared after done", v, 32'h0000_0ABC);
    // R8 done while idle has no effect
    @(negedge clk); term_done = 1'b1;
    @(negedge clk); term_done = 1'b0;
    rd(3'd5, v); chk("R8 idle done ignored", v, 32'h0000_0ABC);
    chk("R8 no spurious pulse", {31'd0, term_req}, 32'd0);

    // R7 a new request is accepted once idle
    wr(3'd5, 32'h0017_7777);
    chk("R7 second pulse", {31'd0, term_req}, 32'd1);
    chk("R7 second pasid", {12'd0, term_pasid}, 32'h0007_7777);

    // R1 reset clears the pending termination
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(3'd5, v); chk("R1 reset clears busy", v, 32'h0);
    finish_run();
  end
endmodule